// File: doc/BRIEF.md
# Shadow Register Refresh Controller

This block holds the live working copy of a sensor conditioner's trim settings: one 12-bit configuration word and four 12-bit coefficient registers (offset, offset temperature coefficient, span and span temperature coefficient). The values come from a 128-bit non-volatile image. The image is split into eight 16-bit words. Only the low 12 bits of each word carry data. Words 0 to 4 feed the five registers in that order. Words 5 to 7 are reserved or user storage and are never loaded.

A load happens in four cases:
- once, just after reset;
- on each rising edge of chip-select, unless the serial front end has latched its update-inhibit flag;
- periodically, while write-enable is high and no host session is active;
- on a host load strobe.

A host can also stage new values through direct writes. A staged value reaches the live registers only on a later load strobe. That load copies only the registers that were written since the last load strobe.

Every load updates all affected registers on one clock edge. The outputs therefore never show a mix of old and new values.

Top module: `shadow_refresh`

## Requirements
- R1: While rst_ni is low, all five register outputs and res_sel_o are zero.
- R2: On the first clock edge after reset release, each register takes the low 12 bits of its word. Word k occupies image bits [16k+15:16k]. The words are assigned as word 0 = configuration, 1 = offset, 2 = offset TC, 3 = span, 4 = span TC.
- R3: Bits [15:12] of every word, and all of words 5 to 7, have no effect on any output.
- R4: If cs_i was low at the previous edge and is high at this edge while upd_inhibit_i is 0, all registers load from the image at this edge. If upd_inhibit_i is 1 on that edge, nothing loads.
- R5: While we_i is 1 and comm_active_i is 0, the registers reload from the image every PERIOD edges. PERIOD is CLK_KHZ*REFRESH_US/1000. The first reload lands on the PERIOD-th edge at which the run condition holds. While we_i is 0 there is no periodic reload, and the count restarts from zero.
- R6: While comm_active_i is 1, periodic reloads stop, and the count restarts when the flag drops.
- R7: A direct write (wr_valid_i, with wr_sel_i 0 to 4 using the word numbering of R2) leaves the outputs unchanged until load_i. At load_i only the written registers take their staged values; the other registers keep their values.
- R8: A direct write with wr_sel_i of 5, 6 or 7 is dropped and changes nothing, even after load_i.
- R9: When load_i and an image load fall on the same edge, the staged registers take their staged values and all other registers take the image values.
- R10: res_sel_o equals bit 7 of the live configuration register (1 = internal resistors selected).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nv_image_i | input | 128 | Non-volatile array image, eight 16-bit words |
| cs_i | input | 1 | Chip-select level, sampled synchronously |
| we_i | input | 1 | Write-enable level; high enables periodic refresh |
| upd_inhibit_i | input | 1 | Latched update-inhibit flag from the serial front end |
| comm_active_i | input | 1 | Host session active; suspends periodic refresh |
| wr_valid_i | input | 1 | Direct-write strobe |
| wr_sel_i | input | 3 | Direct-write target, 0 to 4 |
| wr_data_i | input | 12 | Direct-write value |
| load_i | input | 1 | Commit staged writes to the live registers |
| cfg_o | output | 12 | Live configuration word |
| offs_o | output | 12 | Live offset coefficient |
| offs_tc_o | output | 12 | Live offset temperature coefficient |
| span_o | output | 12 | Live span coefficient |
| span_tc_o | output | 12 | Live span temperature coefficient |
| res_sel_o | output | 1 | Internal resistor select (cfg bit 7) |

## Verification
The assertions assume that all inputs are synchronous to clk_i and change only between edges. They also assume that the image does not move on an edge where a load is expected, since they compare the outputs with the image value from the previous cycle. The stimulus meets these assumptions by driving every input on the falling edge only.

The random phase gives each control input (cs_i, we_i, upd_inhibit_i, comm_active_i, the write strobe and load_i) its own probability. These probabilities are set so that chip-select edges, inhibited edges, refresh windows, and writes followed by loads all occur many times in the run.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int unsigned DW        = 12;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned NUM_WORDS = 8;
  localparam int unsigned NUM_REGS  = 5;
  localparam int unsigned IMG_W     = WORD_W * NUM_WORDS;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned RES_BIT   = 7;

  typedef logic [NUM_REGS-1:0][DW-1:0] bank_t;
endpackage

// File: rtl/shadow_word_pick.sv
module shadow_word_pick
  import shadow_pkg::*;
(
  input  logic [IMG_W-1:0] img_i,
  output bank_t            words_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    assign words_o[k] = img_i[k*WORD_W +: DW];
  end
endmodule

// File: rtl/shadow_tick_gen.sv
module shadow_tick_gen #(
  parameter int unsigned PERIOD = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/shadow_stage.sv
module shadow_stage
  import shadow_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             load_i,
  output bank_t            stage_o,
  output logic [NUM_REGS-1:0] dirty_o
);
  logic [NUM_REGS-1:0] wr_hit;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_stage
    assign wr_hit[k] = wr_valid_i && (wr_sel_i == SEL_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_o[k] <= '0;
        dirty_o[k] <= 1'b0;
      end else begin
        if (wr_hit[k]) stage_o[k] <= wr_data_i;
        // a write landing with the load stays pending for the next load
        dirty_o[k] <= wr_hit[k] | (dirty_o[k] & ~load_i);
      end
    end
  end
endmodule

// File: rtl/shadow_refresh.sv
module shadow_refresh
  import shadow_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 1000,
  parameter int unsigned REFRESH_US = 2500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IMG_W-1:0]  nv_image_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              upd_inhibit_i,
  input  logic              comm_active_i,
  input  logic              wr_valid_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              load_i,
  output logic [DW-1:0]     cfg_o,
  output logic [DW-1:0]     offs_o,
  output logic [DW-1:0]     offs_tc_o,
  output logic [DW-1:0]     span_o,
  output logic [DW-1:0]     span_tc_o,
  output logic              res_sel_o
);
  localparam int unsigned RAW_PERIOD = (CLK_KHZ * REFRESH_US) / 1000;
  localparam int unsigned PERIOD     = (RAW_PERIOD < 2) ? 2 : RAW_PERIOD;

  bank_t               nv_words;
  bank_t               stage;
  bank_t               live_q;
  logic [NUM_REGS-1:0] dirty;
  logic                cs_q, boot_q, tick, cs_rise, nv_load;

  shadow_word_pick u_pick (
    .img_i   (nv_image_i),
    .words_o (nv_words)
  );

  shadow_tick_gen #(.PERIOD(PERIOD)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (we_i && !comm_active_i),
    .tick_o (tick)
  );

  shadow_stage u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .load_i     (load_i),
    .stage_o    (stage),
    .dirty_o    (dirty)
  );

  assign cs_rise = cs_i && !cs_q;
  assign nv_load = boot_q || (cs_rise && !upd_inhibit_i) || tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      cs_q   <= cs_i;
      boot_q <= 1'b0;
    end
  end

  // all registers switch on the same edge; staged values win over the image
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_live
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  live_q[k] <= '0;
      else if (load_i && dirty[k])  live_q[k] <= stage[k];
      else if (nv_load)             live_q[k] <= nv_words[k];
    end
  end

  assign cfg_o     = live_q[0];
  assign offs_o    = live_q[1];
  assign offs_tc_o = live_q[2];
  assign span_o    = live_q[3];
  assign span_tc_o = live_q[4];
  assign res_sel_o = live_q[0][RES_BIT];
endmodule

// File: rtl/shadow_refresh_chk.sv
module shadow_refresh_chk
  import shadow_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IMG_W-1:0] nv_image_i,
  input logic             cs_i,
  input logic             we_i,
  input logic             upd_inhibit_i,
  input logic             comm_active_i,
  input logic             load_i,
  input logic [DW-1:0]    cfg_o,
  input logic [DW-1:0]    offs_o,
  input logic [DW-1:0]    offs_tc_o,
  input logic [DW-1:0]    span_o,
  input logic [DW-1:0]    span_tc_o
);
  logic       cs_seen_q, started_q;
  logic [5*DW-1:0] outs;
  logic       rise_ok;

  assign outs    = {cfg_o, offs_o, offs_tc_o, span_o, span_tc_o};
  assign rise_ok = cs_i && !cs_seen_q && !upd_inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_seen_q <= 1'b0;
      started_q <= 1'b0;
    end else begin
      cs_seen_q <= cs_i;
      started_q <= 1'b1;
    end
  end

  a_r2_boot_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!started_q && !load_i) |=> (cfg_o == $past(nv_image_i[11:0]))
                                && (span_tc_o == $past(nv_image_i[75:64])));

  a_r4_cs_rise_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && rise_ok && !load_i) |=> (offs_o == $past(nv_image_i[27:16]))
                                          && (span_o == $past(nv_image_i[59:48])));

  a_r5_hold_without_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !load_i && !rise_ok && !(we_i && !comm_active_i)) |=> $stable(outs));

  a_r6_comm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && comm_active_i && !load_i && !rise_ok) |=> $stable(outs));
endmodule

bind shadow_refresh shadow_refresh_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .nv_image_i    (nv_image_i),
  .cs_i          (cs_i),
  .we_i          (we_i),
  .upd_inhibit_i (upd_inhibit_i),
  .comm_active_i (comm_active_i),
  .load_i        (load_i),
  .cfg_o         (cfg_o),
  .offs_o        (offs_o),
  .offs_tc_o     (offs_tc_o),
  .span_o        (span_o),
  .span_tc_o     (span_tc_o)
);

// File: tb/shadow_refresh_bench.sv
module shadow_refresh_bench;
  localparam int CLK_KHZ = 8;
  localparam int REFRESH_US = 5000;
  localparam int P = CLK_KHZ * REFRESH_US / 1000;  // 40 edges

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] img = '0;
  logic cs = 0, we = 0, inh = 0, comm = 0, wr_v = 0, ld = 0;
  logic [2:0] wr_sel = 0;
  logic [11:0] wr_d = 0;
  logic [11:0] cfg, offs, offs_tc, span, span_tc;
  logic res_sel;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  shadow_refresh #(.CLK_KHZ(CLK_KHZ), .REFRESH_US(REFRESH_US)) u_shadow_refresh (
    .clk_i(clk), .rst_ni(rst_n), .nv_image_i(img), .cs_i(cs), .we_i(we),
    .upd_inhibit_i(inh), .comm_active_i(comm), .wr_valid_i(wr_v),
    .wr_sel_i(wr_sel), .wr_data_i(wr_d), .load_i(ld),
    .cfg_o(cfg), .offs_o(offs), .offs_tc_o(offs_tc), .span_o(span),
    .span_tc_o(span_tc), .res_sel_o(res_sel));

  function automatic logic [11:0] word_of(logic [127:0] im, int k);
    return im[16*k +: 12];
  endfunction

  // reference model built from the requirements
  logic [11:0] m_live [5];
  logic [11:0] m_stage [5];
  logic        m_dirty [5];
  logic        m_cs, m_boot;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin
        m_live[k] = '0; m_stage[k] = '0; m_dirty[k] = 1'b0;
      end
      m_cs = 1'b0; m_boot = 1'b1; m_cnt = 0;
    end else begin
      logic run, tick, nvl;
      run  = we && !comm;
      tick = run && (m_cnt == P - 1);
      nvl  = m_boot || (cs && !m_cs && !inh) || tick;
      for (int k = 0; k < 5; k++) begin
        if (ld && m_dirty[k]) m_live[k] = m_stage[k];
        else if (nvl)         m_live[k] = word_of(img, k);
        if (ld) m_dirty[k] = 1'b0;
        if (wr_v && wr_sel == 3'(k)) begin
          m_stage[k] = wr_d; m_dirty[k] = 1'b1;
        end
      end
      m_cnt  = (!run || tick) ? 0 : m_cnt + 1;
      m_cs   = cs;
      m_boot = 1'b0;
    end
  end

  task automatic cmp(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    cmp({tag, " cfg"}, cfg, m_live[0]);
    cmp({tag, " offs"}, offs, m_live[1]);
    cmp({tag, " offs_tc"}, offs_tc, m_live[2]);
    cmp({tag, " span"}, span, m_live[3]);
    cmp({tag, " span_tc"}, span_tc, m_live[4]);
    cmp({tag, " R10 res_sel"}, {11'b0, res_sel}, {11'b0, m_live[0][7]});
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [127:0] rnd_img();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [11:0] hold [5];
    logic [127:0] alt;
    void'($urandom(32'h5EED_0042));
    img = rnd_img();
    step(2);
    cmp("R1 reset cfg", cfg, 12'h0);
    cmp("R1 reset span_tc", span_tc, 12'h0);
    cmp("R1 reset res_sel", {11'b0, res_sel}, 12'h0);
    rst_n = 1'b1;
    step(1);
    for (int k = 0; k < 5; k++) hold[k] = word_of(img, k);
    cmp("R2 boot cfg", cfg, hold[0]);
    cmp("R2 boot offs", offs, hold[1]);
    cmp("R2 boot span_tc", span_tc, hold[4]);
    chk_all("R2");

    // R3: flip reserved nibbles and words 5..7, reload via cs
    alt = ~img;
    for (int k = 0; k < 5; k++) alt[16*k +: 12] = img[16*k +: 12];
    img = alt; cs = 1; step(1); cs = 0;
    cmp("R3 cfg", cfg, hold[0]);
    cmp("R3 span", span, hold[3]);
    step(1);

    // R4 load on cs rise, then inhibited rise
    img = rnd_img(); cs = 1; step(1);
    cmp("R4 rise offs_tc", offs_tc, word_of(img, 2));
    chk_all("R4");
    cs = 0; step(1);
    hold[2] = offs_tc; img = rnd_img(); inh = 1; cs = 1; step(1);
    cmp("R4 inhibited", offs_tc, hold[2]);
    cs = 0; inh = 0; step(1);

    // R5 periodic refresh
    hold[1] = offs; img = rnd_img(); we = 1;
    step(P - 1);
    cmp("R5 before period", offs, hold[1]);
    step(1);
    cmp("R5 at period", offs, word_of(img, 1));
    we = 0; hold[1] = offs; img = rnd_img();
    step(2 * P);
    cmp("R5 we low no refresh", offs, hold[1]);

    // R6 comm suspends
    we = 1; comm = 1; step(2 * P);
    cmp("R6 comm hold", offs, hold[1]);
    comm = 0; step(P - 1);
    cmp("R6 restart before", offs, hold[1]);
    step(1);
    cmp("R6 restart at period", offs, word_of(img, 1));
    we = 0; step(1);

    // R7 staged write
    hold[0] = cfg; hold[3] = span;
    wr_v = 1; wr_sel = 3; wr_d = 12'hA5C; step(1); wr_v = 0;
    step(3);
    cmp("R7 staged no effect", span, hold[3]);
    ld = 1; step(1); ld = 0;
    cmp("R7 load span", span, 12'hA5C);
    cmp("R7 cfg kept", cfg, hold[0]);

    // R8 bad select
    hold[4] = span_tc;
    wr_v = 1; wr_sel = 6; wr_d = 12'h3C3; step(1); wr_v = 0;
    ld = 1; step(1); ld = 0;
    chk_all("R8 bad select");
    cmp("R8 span_tc kept", span_tc, hold[4]);

    // R9 host load meets image load
    wr_v = 1; wr_sel = 0; wr_d = 12'h080; step(1); wr_v = 0;
    img = rnd_img(); cs = 1; ld = 1; step(1); cs = 0; ld = 0;
    cmp("R9 staged wins cfg", cfg, 12'h080);
    cmp("R9 image offs", offs, word_of(img, 1));
    cmp("R10 res_sel high", {11'b0, res_sel}, 12'h1);
    step(1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      chk_all("RND R4 R5 R6 R7 R9");
      if ($urandom_range(0, 15) == 0) img = rnd_img();
      if ($urandom_range(0, 7) == 0) cs = ~cs;
      if ($urandom_range(0, 63) == 0) we = ~we;
      if ($urandom_range(0, 31) == 0) inh = ~inh;
      if ($urandom_range(0, 47) == 0) comm = ~comm;
      wr_v = ($urandom_range(0, 5) == 0);
      wr_sel = 3'($urandom_range(0, 7));
      wr_d = 12'($urandom);
      ld = ($urandom_range(0, 9) == 0);
      step(1);
    end
    chk_all("RND end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule